// File: doc/BRIEF.md
# Replay-from-Mark FIFO Controller

A single-clock FIFO with configurable data width and depth. Besides normal first-in first-out storage, it lets a stretch of stored data be read again as many times as needed, starting from a position picked at run time. A static mode input chooses between two read styles. In standard mode, each word is fetched by a read enable. In fall-through mode, the head word is presented automatically and a read enable moves on to the next word.

While `mark` is high, the word currently held in the read output register becomes the mark, and the mark follows the read position until `mark` is sampled low. Dropping `mark` leaves mark mode. While mark mode is active, the storage from the mark onward is protected: the write side reports full as soon as its pointer would land on the marked slot. A replay request is made by holding `rt_n` low for one clock with reads idle. The request is accepted only if at least `RT_MIN_GAP` words separate the write pointer from the mark. A fixed two-cycle setup then rewinds the read pointer to the mark. During setup, the status flag shows "nothing to read".

Top module: `rtx_fifo`

## Requirements
- R1: After reset, `full` and `rt_err` are 0, and `status_flag` reads "nothing to read": 1 in standard mode (`fwft_mode`=0), 0 in fall-through mode (`fwft_mode`=1).
- R2: In standard mode, `status_flag` is 1 exactly when no word is stored or a replay setup is running. A `rd_en` sampled while it is 0 places the oldest word on `rd_data` after that edge, in write order.
- R3: In fall-through mode, `status_flag` is 1 when `rd_data` holds a valid head word, which appears without any `rd_en`. A `rd_en` sampled while the flag is 1 consumes that word.
- R4: Outside mark mode, `full` is 1 when DEPTH words are stored (fall-through: excluding the word in the output register). A write while full is dropped.
- R5: On each edge with `mark`=1 and the FIFO not full, the mark moves to the word in the output register, replacing any earlier mark. Standard mode also requires a word to be stored. Fall-through mode also requires `status_flag`=1.
- R6: In mark mode, `full` is 1 when the write pointer has advanced DEPTH slots beyond the mark. Writes are then dropped, so the marked slot is never overwritten.
- R7: A replay request (`rt_n`=0, `rd_en`=0, mark mode, write-to-mark distance ≥ `RT_MIN_GAP`) forces `status_flag` to "nothing to read" for the two cycles after the request edge.
- R8: After setup in standard mode, the first `rd_en` returns the marked word and further reads return the words that followed it.
- R9: After setup in fall-through mode, the marked word appears on `rd_data` with `status_flag`=1 one edge after setup ends, without `rd_en`.
- R10: A replay request that is outside mark mode, has `rd_en`=1, or has a distance below `RT_MIN_GAP` is ignored, and `rt_err` is 1 for exactly the one cycle after it.
- R11: An edge with `mark`=0 outside setup ends mark mode, after which a replay request is rejected as in R10.
- R12: During setup, `rd_en` is ignored and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fwft_mode | input | 1 | Static read style: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| full | output | 1 | No room for a write |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read output register |
| status_flag | output | 1 | Empty (standard) or head-valid (fall-through) |
| mark | input | 1 | Mark select, level sensitive |
| rt_n | input | 1 | Replay request, active low |
| rt_err | output | 1 | One-cycle pulse on a rejected replay request |

## Verification
Several properties are checked every cycle:
- the write pointer never moves past DEPTH slots beyond the mark, and stays put when a write meets a full FIFO;
- occupancy never exceeds the depth;
- setup lasts exactly two cycles, and the read pointer equals the mark right after the rewind;
- `rd_data` is frozen through setup;
- a request outside mark mode always produces the error pulse.

Only the bench scenarios can show that:
- the replayed stream starts at the latest mark rather than an earlier one;
- fall-through mode presents the marked word with no read enable;
- data order survives a full fill and drain.

// File: rtl/rtx_pkg.sv
// Package: shared types for the replay FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rtx_pkg;
    // Replay setup sequencer states
    typedef enum logic [1:0] {
        RT_IDLE   = 2'd0,
        RT_LOAD   = 2'd1,
        RT_SETTLE = 2'd2
    } rt_state_t;
endpackage

// File: rtl/rtx_mem.sv
// Module: rtx_mem
// Storage array with one synchronous write port and one combinational read port.
// Assumes: addresses are in range; no reset is needed on the contents.
module rtx_mem #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Capture a word on each accepted write
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Present the word at the read pointer
    assign rdata = store[raddr];
endmodule

// File: rtl/rtx_mark_ctl.sv
// Module: rtx_mark_ctl
// Holds the mark position and the mark-mode flag, and runs the two-cycle
// replay setup sequencer. It flags illegal replay requests.
// Assumes: pointers carry one extra lap bit (AW+1 wide), and the distance
// from the mark to the write pointer never exceeds the depth.
module rtx_mark_ctl
    import rtx_pkg::*;
#(
    parameter int AW         = 7,
    parameter int RT_MIN_GAP = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mark_i,
    input  logic        rt_n_i,
    input  logic        rd_en_i,
    input  logic        has_word_i,
    input  logic        room_i,
    input  logic [AW:0] wptr_i,
    input  logic [AW:0] rptr_i,
    output logic        marked_o,
    output logic [AW:0] mark_ptr_o,
    output logic        busy_o,
    output logic        rewind_o,
    output logic        rt_err_o
);
    localparam logic [AW:0] GAP_W = RT_MIN_GAP[AW:0];

    rt_state_t   state;
    logic [AW:0] gap;
    logic        rt_ok;

    // Distance from the mark to the write pointer, and the legality of a request
    assign gap   = wptr_i - mark_ptr_o;
    assign rt_ok = marked_o && !rd_en_i && (gap >= GAP_W);

    // Sequencer, mark register and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RT_IDLE;
            marked_o   <= 1'b0;
            mark_ptr_o <= '0;
            rt_err_o   <= 1'b0;
        end else begin
            rt_err_o <= 1'b0;
            case (state)
                RT_IDLE: begin
                    if (!rt_n_i) begin
                        if (rt_ok) begin
                            state <= RT_LOAD;
                        end else begin
                            rt_err_o <= 1'b1;
                        end
                    end
                end
                RT_LOAD:   state <= RT_SETTLE;
                default:   state <= RT_IDLE;
            endcase
            if (state == RT_IDLE) begin
                if (!mark_i) begin
                    marked_o <= 1'b0;
                end else if (has_word_i && room_i) begin
                    marked_o   <= 1'b1;
                    mark_ptr_o <= rptr_i - 1'b1;
                end
            end
        end
    end

    assign busy_o   = (state != RT_IDLE);
    assign rewind_o = (state == RT_LOAD);
endmodule

// File: rtl/rtx_rd_port.sv
// Module: rtx_rd_port
// Read pointer and output register, for both standard and fall-through styles.
// The rewind strobe reloads the read pointer from the mark.
// Assumes: mem_q_i is the stored word at rptr_o; fwft_i is static after reset.
module rtx_rd_port #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_i,
    input  logic          rd_en_i,
    input  logic          busy_i,
    input  logic          rewind_i,
    input  logic [AW:0]   mark_ptr_i,
    input  logic [AW:0]   wptr_i,
    input  logic [DW-1:0] mem_q_i,
    output logic [AW:0]   rptr_o,
    output logic [DW-1:0] rd_data_o,
    output logic          out_valid_o
);
    logic [AW:0] count;
    logic        stored;
    logic        std_take;
    logic        ff_load;
    logic        ff_drop;

    // Decide this cycle's transfer for each read style
    assign count    = wptr_i - rptr_o;
    assign stored   = (count != '0);
    assign std_take = rd_en_i && stored && !busy_i;
    assign ff_load  = !busy_i && stored && (!out_valid_o || rd_en_i);
    assign ff_drop  = !busy_i && rd_en_i && out_valid_o && !stored;

    // Advance, rewind or hold the read side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_o      <= '0;
            rd_data_o   <= '0;
            out_valid_o <= 1'b0;
        end else if (rewind_i) begin
            rptr_o      <= mark_ptr_i;
            out_valid_o <= 1'b0;
        end else if (fwft_i) begin
            if (ff_load) begin
                rd_data_o   <= mem_q_i;
                rptr_o      <= rptr_o + 1'b1;
                out_valid_o <= 1'b1;
            end else if (ff_drop) begin
                out_valid_o <= 1'b0;
            end
        end else if (std_take) begin
            rd_data_o <= mem_q_i;
            rptr_o    <= rptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/rtx_fifo.sv
// Module: rtx_fifo (top)
// Single-clock FIFO with replay from a run-time mark. It ties the storage,
// the read port and the mark controller together, and owns the write pointer
// and the full and status flags.
// Assumes: fwft_mode is static between resets; DEPTH = 2**AW exceeds RT_MIN_GAP.
module rtx_fifo #(
    parameter int DW         = 8,
    parameter int AW         = 7,
    parameter int RT_MIN_GAP = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          status_flag,
    input  logic          mark,
    input  logic          rt_n,
    output logic          rt_err
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    logic [AW:0]   wptr;
    logic [AW:0]   rptr;
    logic [AW:0]   mark_ptr;
    logic [AW:0]   count;
    logic [DW-1:0] mem_q;
    logic          marked;
    logic          busy;
    logic          rewind;
    logic          out_valid;
    logic          wr_go;
    logic          has_word;
    logic          room;

    // Occupancy, full limit and status flag
    assign count       = wptr - rptr;
    assign room        = (count != FULL_CNT);
    assign full        = marked ? ((wptr - mark_ptr) == FULL_CNT) : !room;
    assign wr_go       = wr_en && !full;
    assign has_word    = fwft_mode ? out_valid : (count != '0);
    assign status_flag = fwft_mode ? (out_valid && !busy) : (busy || (count == '0));

    // Write pointer advance on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (wr_go) begin
            wptr <= wptr + 1'b1;
        end
    end

    rtx_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (rptr[AW-1:0]),
        .rdata (mem_q)
    );

    rtx_rd_port #(.DW(DW), .AW(AW)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .fwft_i      (fwft_mode),
        .rd_en_i     (rd_en),
        .busy_i      (busy),
        .rewind_i    (rewind),
        .mark_ptr_i  (mark_ptr),
        .wptr_i      (wptr),
        .mem_q_i     (mem_q),
        .rptr_o      (rptr),
        .rd_data_o   (rd_data),
        .out_valid_o (out_valid)
    );

    rtx_mark_ctl #(.AW(AW), .RT_MIN_GAP(RT_MIN_GAP)) u_mark (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_i     (mark),
        .rt_n_i     (rt_n),
        .rd_en_i    (rd_en),
        .has_word_i (has_word),
        .room_i     (room),
        .wptr_i     (wptr),
        .rptr_i     (rptr),
        .marked_o   (marked),
        .mark_ptr_o (mark_ptr),
        .busy_o     (busy),
        .rewind_o   (rewind),
        .rt_err_o   (rt_err)
    );
endmodule

// File: rtl/rtx_fifo_chk.sv
// Module: rtx_fifo_chk
// Cycle-by-cycle properties for rtx_fifo, attached with bind.
// Assumes: the signal names of rtx_fifo shown in the bind below.
module rtx_fifo_chk #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          full,
    input logic          rt_n,
    input logic          rt_err,
    input logic          marked,
    input logic          busy,
    input logic          rewind,
    input logic [AW:0]   wptr,
    input logic [AW:0]   rptr,
    input logic [AW:0]   mark_ptr,
    input logic [DW-1:0] rd_data
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    assert_mark_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        marked |-> ((wptr - mark_ptr) <= FULL_CNT));

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wptr));

    assert_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wptr - rptr) <= FULL_CNT));

    assert_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rptr == $past(mark_ptr)));

    assert_setup_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    assert_setup_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    assert_setup_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_data));

    assert_unmarked_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && !busy && !marked) |=> rt_err);
endmodule

bind rtx_fifo rtx_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .full     (full),
    .rt_n     (rt_n),
    .rt_err   (rt_err),
    .marked   (marked),
    .busy     (busy),
    .rewind   (rewind),
    .wptr     (wptr),
    .rptr     (rptr),
    .mark_ptr (mark_ptr),
    .rd_data  (rd_data)
);

// File: tb/tb_rtx_fifo.sv
// Bench for rtx_fifo. Read tasks push expected words into a queue, and a
// monitor pops and compares them as the design delivers data.
module tb_rtx_fifo;
    localparam int DW = 8;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          status_flag;
    logic          mark = 1'b0;
    logic          rt_n = 1'b1;
    logic          rt_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit rd_pend = 1'b0;
    string cur_req = "R2";
    logic [DW-1:0] exp_q[$];

    always #2 clk = ~clk;

    rtx_fifo #(.DW(DW), .AW(AW), .RT_MIN_GAP(64)) dut (
        .clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .status_flag(status_flag),
        .mark(mark), .rt_n(rt_n), .rt_err(rt_err)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Monitor: compare delivered words against the scoreboard queue
    always @(negedge clk) begin
        if (rd_pend || (fwft_mode && rd_en && status_flag && rst_n)) begin
            if (exp_q.size() == 0) begin
                chk(cur_req, "unexpected read word", int'(rd_data), -1);
            end else begin
                chk(cur_req, "read word", int'(rd_data), int'(exp_q.pop_front()));
            end
        end
        rd_pend = !fwft_mode && rd_en && !status_flag && rst_n;
    end

    task automatic do_reset(input logic mode);
        fwft_mode = mode;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; mark = 1'b0; rt_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_run(input int n, input int first);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_data = DW'(first + i);
        end
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd_run(input int n, input int first);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rd_en = 1'b1; exp_q.push_back(DW'(first + i));
        end
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic rt_pulse();
        @(posedge clk); #1 rt_n = 1'b0;
        @(posedge clk); #1 rt_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        @(negedge clk);
        chk("R1", "empty flag", status_flag, 1);
        chk("R1", "full", full, 0);
        chk("R1", "rt_err", rt_err, 0);

        wr_run(10, 1);
        idle(2);
        @(negedge clk);
        chk("R2", "empty flag after writes", status_flag, 0);
        cur_req = "R2";
        rd_run(3, 1);

        rt_pulse();  // not in mark mode
        chk("R10", "rt_err unmarked", rt_err, 1);
        chk("R10", "flag unaffected", status_flag, 0);
        @(negedge clk);
        chk("R10", "rt_err pulse width", rt_err, 0);

        idle(1);
        mark = 1'b1;
        idle(1);            // mark on word 3
        cur_req = "R5";
        rd_run(2, 4);       // mark follows the reads
        idle(1);            // R5: mark replaced, now on word 5
        rt_pulse();         // distance 6 < 64
        chk("R10", "rt_err short gap", rt_err, 1);

        wr_run(125, 11);    // only 122 fit before the mark slot
        idle(1);
        @(negedge clk);
        chk("R6", "full at mark", full, 1);

        @(posedge clk); #1 rt_n = 1'b0; mark = 1'b0;
        @(posedge clk); #1 rt_n = 1'b1;
        @(negedge clk);
        chk("R7", "flag forced setup 1", status_flag, 1);
        @(posedge clk); #1 rd_en = 1'b1;   // R12: ignored
        @(negedge clk);
        chk("R7", "flag forced setup 2", status_flag, 1);
        @(posedge clk); #1 rd_en = 1'b0;
        @(negedge clk);
        chk("R7", "flag released", status_flag, 0);
        chk("R12", "rd_data held", int'(rd_data), 5);
        chk("R7", "rt_err on legal request", rt_err, 0);

        cur_req = "R8";
        rd_run(10, 5);      // replay starts at the latest mark
        idle(2);
        rt_pulse();
        chk("R11", "rt_err after mark mode left", rt_err, 1);
        chk("R11", "flag unaffected", status_flag, 0);
        chk("R8", "scoreboard drained", exp_q.size(), 0);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        @(negedge clk);
        chk("R1", "ready flag", status_flag, 0);
        chk("R1", "full", full, 0);
        chk("R1", "rt_err", rt_err, 0);

        wr_run(70, 1);
        idle(3);
        @(negedge clk);
        chk("R3", "head valid", status_flag, 1);
        chk("R3", "head word", int'(rd_data), 1);
        cur_req = "R3";
        rd_run(3, 1);

        mark = 1'b1;
        idle(1);            // mark on word 4
        cur_req = "R10";
        rt_n = 1'b0; rd_en = 1'b1; exp_q.push_back(DW'(4));
        @(posedge clk); #1 rt_n = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        chk("R10", "rt_err with read enabled", rt_err, 1);
        idle(1);            // mark moves to word 5

        @(posedge clk); #1 rt_n = 1'b0; mark = 1'b0;
        @(posedge clk); #1 rt_n = 1'b1;
        @(negedge clk);
        chk("R7", "ready forced low 1", status_flag, 0);
        @(negedge clk);
        chk("R7", "ready forced low 2", status_flag, 0);
        @(negedge clk);
        chk("R9", "ready before reload", status_flag, 0);
        @(negedge clk);
        chk("R9", "ready after reload", status_flag, 1);
        chk("R9", "marked word", int'(rd_data), 5);

        cur_req = "R9";
        rd_run(3, 5);
        wr_run(70, 71);     // 66 fit
        idle(1);
        @(negedge clk);
        chk("R4", "full at depth", full, 1);
        cur_req = "R4";
        rd_run(129, 8);
        idle(3);
        @(negedge clk);
        chk("R4", "ready after drain", status_flag, 0);
        chk("R4", "full after drain", full, 0);
        chk("R4", "scoreboard drained", exp_q.size(), 0);

        finish_run();
    end
endmodule